// File: doc/BRIEF.md
# Keyed Configuration Item Port

This block is a small register-mapped slave through which a host pulls configuration items out as byte streams, and pushes new bytes into the items that allow it. The host first writes a 16-bit key into a selector register. From then on, every access to the data register moves bytes of the chosen item. An internal offset pointer tracks the position in that item, and it advances by one for each byte moved.

The data register carries up to eight bytes per access. A wide access is handled as that many consecutive single-byte transfers. The earliest byte of the stream always sits in the lowest byte lane. Writing the selector rewinds the stream to the first byte of the newly chosen item.

Two items are built in and read-only:
- a four-character presence signature under key 0x0000;
- an interface revision word under key 0x0001.

All other items live in a small byte store. Parameters set each item's key, base, length and write permission.

Top module: `cfgblob_port`

## Requirements
- R1: After reset, bus_ready and bus_rdata are zero. The selected key is 0x0000 and the stream position is zero, so a first 4-byte data read returns the signature without any selector write.
- R2: A 2-byte write (bus_size = 1) at byte offset 8 loads the selector. The key is taken big-endian: bus_wdata[7:0] is the key's upper byte and bus_wdata[15:8] its lower byte. A read at offset 8 returns zero.
- R3: Key 0x0000 streams the ASCII bytes 'C','F','G','P' (0x43, 0x46, 0x47, 0x50), in that order. A single 4-byte read therefore returns 0x50474643.
- R4: Key 0x0001 streams a 4-byte revision value, least significant byte first. The value is zero.
- R5: bus_size n (0..3) at offset 0 moves 2^n bytes. Byte lane i (bus_wdata/bus_rdata bits 8i+7:8i) is stream position P+i, where P is the position before the access. The position then advances by 2^n. Lanes at or above 2^n read zero.
- R6: Every selector write sets the stream position to zero, including a reselect of the current key.
- R7: Stream positions at or past an item's length, and every position of a key with no item, read as 0x00.
- R8: For a writable item, a data write stores lane i into item byte P+i. A later reselect and read returns the stored bytes.
- R9: Write bytes at or past an item's length, writes to read-only items, and writes to unknown keys change no stored byte. The position still advances.
- R10: A data access at any byte offset other than 0 or 8 is ignored. It reads zero and moves neither the position nor the selector.
- R11: Every cycle holding bus_rd or bus_wr produces bus_ready high in the next cycle, and only then. bus_rdata is zero in the ready cycle of any write. Back-to-back accesses in consecutive cycles are accepted.
- R12: After reset, byte j of the item store holds (5 + 17*j) mod 256. With the default map, key 0x0010 (writable) covers bytes 0..7, key 0x0020 (read-only) covers bytes 8..13, and key 0x0100 (writable) covers bytes 16..31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| bus_wdata | input | 64 | Write data, earliest stream byte in bits 7:0 |
| bus_rdata | output | 64 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Completion of the access taken in the previous cycle |

## Verification
Two of this block's functions can fall in the same cycle.

The first case is a selector write followed at once by a data read. The ready cycle of the rewind is then also the cycle in which the read is accepted. The bench issues these back to back and requires that the read already sees the new key at position zero.

The second case is a single wide write that straddles an item's end. It stores its lower lanes and drops its upper lanes in the same cycle. A reselect and read-back judges both effects, and also confirms that the neighbouring item is untouched.

// File: rtl/cfgblob_pkg.sv
package cfgblob_pkg;

   localparam int DATA_BYTES = 8;
   localparam int DATA_W     = DATA_BYTES * 8;
   localparam int KEY_W      = 16;
   localparam int FIELD_W    = 16;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SIG  = 2'd1,
      SRC_REV  = 2'd2,
      SRC_MEM  = 2'd3
   } src_e;

   function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/cfgblob_keymap.sv
module cfgblob_keymap
   import cfgblob_pkg::*;
#(
   parameter int NUM_ITEMS = 3,
   parameter int MEM_AW    = 5,
   parameter logic [NUM_ITEMS*KEY_W-1:0]   ITEM_KEYS     = '0,
   parameter logic [NUM_ITEMS*FIELD_W-1:0] ITEM_BASES    = '0,
   parameter logic [NUM_ITEMS*FIELD_W-1:0] ITEM_LENS     = '0,
   parameter logic [NUM_ITEMS-1:0]         ITEM_WRITABLE = '0,
   parameter logic [KEY_W-1:0]             SIG_KEY       = 16'h0000,
   parameter logic [KEY_W-1:0]             REV_KEY       = 16'h0001
) (
   input  logic [KEY_W-1:0]   key,
   output src_e               src,
   output logic [MEM_AW-1:0]  base,
   output logic [FIELD_W-1:0] len,
   output logic               wen
);

   logic [NUM_ITEMS-1:0] hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ITEMS; gi++) begin : g_match
         assign hit[gi] = (key == ITEM_KEYS[gi*KEY_W +: KEY_W]);
      end
   endgenerate

   always_comb begin
      src  = SRC_NONE;
      base = '0;
      len  = '0;
      wen  = 1'b0;
      if (key == SIG_KEY) begin
         src = SRC_SIG;
      end else if (key == REV_KEY) begin
         src = SRC_REV;
      end else begin
         // lowest index wins when two table entries share a key
         for (int i = NUM_ITEMS - 1; i >= 0; i--) begin
            if (hit[i]) begin
               src  = SRC_MEM;
               base = MEM_AW'(ITEM_BASES[i*FIELD_W +: FIELD_W]);
               len  = ITEM_LENS[i*FIELD_W +: FIELD_W];
               wen  = ITEM_WRITABLE[i];
            end
         end
      end
   end

endmodule

// File: rtl/cfgblob_store.sv
module cfgblob_store #(
   parameter int DEPTH     = 32,
   parameter int AW        = 5,
   parameter int LANES     = 8,
   parameter int INIT_BASE = 5,
   parameter int INIT_STEP = 17
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0][AW-1:0]  lane_addr,
   input  logic [LANES-1:0]          lane_we,
   input  logic [LANES-1:0][7:0]     lane_wdata,
   output logic [LANES-1:0][7:0]     lane_rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) begin
            mem[j] <= 8'(INIT_BASE + j * INIT_STEP);
         end
      end else begin
         for (int i = 0; i < LANES; i++) begin
            if (lane_we[i]) begin
               mem[lane_addr[i]] <= lane_wdata[i];
            end
         end
      end
   end

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_rd
         assign lane_rdata[gl] = mem[lane_addr[gl]];
      end
   endgenerate

endmodule

// File: rtl/cfgblob_lanes.sv
module cfgblob_lanes
   import cfgblob_pkg::*;
#(
   parameter int          OFS_W     = 16,
   parameter int          MEM_AW    = 5,
   parameter logic [31:0] SIGNATURE = 32'h43464750,
   parameter logic [31:0] REVISION  = 32'h0000_0000
) (
   input  src_e                          src,
   input  logic [MEM_AW-1:0]             base,
   input  logic [FIELD_W-1:0]            len,
   input  logic                          wen,
   input  logic [OFS_W-1:0]              ofs,
   input  logic [3:0]                    nbytes,
   input  logic                          do_wr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [DATA_BYTES-1:0][7:0]    mem_rdata,
   output logic [DATA_BYTES-1:0][MEM_AW-1:0] mem_addr,
   output logic [DATA_BYTES-1:0]         mem_we,
   output logic [DATA_BYTES-1:0][7:0]    mem_wdata,
   output logic [DATA_W-1:0]             rd_lanes
);

   genvar gl;
   generate
      for (gl = 0; gl < DATA_BYTES; gl++) begin : g_lane
         logic [31:0] pos;
         logic        active;
         logic        in_item;
         logic        in_word;
         logic [7:0]  sig_b;
         logic [7:0]  rev_b;
         logic [7:0]  byte_v;

         assign pos     = 32'(ofs) + 32'(gl);
         assign active  = 4'(gl) < nbytes;
         assign in_item = pos < 32'(len);
         assign in_word = pos < 32'd4;

         always_comb begin
            case (pos[1:0])
               2'd0:    sig_b = SIGNATURE[31:24];
               2'd1:    sig_b = SIGNATURE[23:16];
               2'd2:    sig_b = SIGNATURE[15:8];
               default: sig_b = SIGNATURE[7:0];
            endcase
            case (pos[1:0])
               2'd0:    rev_b = REVISION[7:0];
               2'd1:    rev_b = REVISION[15:8];
               2'd2:    rev_b = REVISION[23:16];
               default: rev_b = REVISION[31:24];
            endcase
         end

         always_comb begin
            byte_v = 8'h00;
            unique case (src)
               SRC_SIG:  byte_v = in_word ? sig_b : 8'h00;
               SRC_REV:  byte_v = in_word ? rev_b : 8'h00;
               SRC_MEM:  byte_v = in_item ? mem_rdata[gl] : 8'h00;
               default:  byte_v = 8'h00;
            endcase
         end

         assign rd_lanes[gl*8 +: 8] = active ? byte_v : 8'h00;
         assign mem_addr[gl]  = (src == SRC_MEM && in_item) ? (base + MEM_AW'(pos)) : '0;
         assign mem_we[gl]    = do_wr && active && (src == SRC_MEM) && wen && in_item;
         assign mem_wdata[gl] = wdata[gl*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/cfgblob_port.sv
module cfgblob_port
   import cfgblob_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int          OFS_W     = 16,
   parameter int          MEM_BYTES = 32,
   parameter int          NUM_ITEMS = 3,
   parameter logic [NUM_ITEMS*KEY_W-1:0]   ITEM_KEYS     = {16'h0100, 16'h0020, 16'h0010},
   parameter logic [NUM_ITEMS*FIELD_W-1:0] ITEM_BASES    = {16'd16, 16'd8, 16'd0},
   parameter logic [NUM_ITEMS*FIELD_W-1:0] ITEM_LENS     = {16'd16, 16'd6, 16'd8},
   parameter logic [NUM_ITEMS-1:0]         ITEM_WRITABLE = 3'b101,
   parameter logic [31:0] SIGNATURE = 32'h43464750,
   parameter int          INIT_BASE = 5,
   parameter int          INIT_STEP = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   output logic              bus_ready
);

   localparam int          MEM_AW     = $clog2(MEM_BYTES);
   localparam logic [31:0] REVISION   = 32'h0000_0000;
   localparam logic [ADDR_W-1:0] DATA_OFS = '0;
   localparam logic [ADDR_W-1:0] SEL_OFS  = ADDR_W'(8);

   initial begin
      assert (ADDR_W >= 4) else $error("ADDR_W must reach offset 8");
      assert (OFS_W >= 8 && OFS_W <= 31) else $error("OFS_W out of range");
      assert (MEM_BYTES >= 8 && (1 << MEM_AW) == MEM_BYTES)
         else $error("MEM_BYTES must be a power of two of at least 8");
      assert (NUM_ITEMS >= 1) else $error("NUM_ITEMS must be positive");
      for (int i = 0; i < NUM_ITEMS; i++) begin
         assert (int'(ITEM_BASES[i*FIELD_W +: FIELD_W]) + int'(ITEM_LENS[i*FIELD_W +: FIELD_W])
                 <= MEM_BYTES) else $error("item %0d exceeds store", i);
         assert (ITEM_KEYS[i*KEY_W +: KEY_W] > 16'h0001)
            else $error("item %0d uses a built-in key", i);
      end
   end

   // bus decode: a cycle with both strobes counts as a read
   logic       is_data, is_sel, any_acc;
   logic       data_rd, data_wr, data_acc, sel_wr;
   logic [3:0] nbytes;

   assign is_data  = (bus_addr == DATA_OFS);
   assign is_sel   = (bus_addr == SEL_OFS);
   assign any_acc  = bus_rd | bus_wr;
   assign data_rd  = bus_rd & is_data;
   assign data_wr  = bus_wr & ~bus_rd & is_data;
   assign data_acc = data_rd | data_wr;
   assign sel_wr   = bus_wr & ~bus_rd & is_sel & (bus_size == 2'd1);
   assign nbytes   = size_to_bytes(bus_size);

   // selector and stream position
   logic [KEY_W-1:0] sel_q;
   logic [OFS_W-1:0] ofs_q;
   logic [OFS_W:0]   ofs_sum;

   assign ofs_sum = {1'b0, ofs_q} + (OFS_W + 1)'(nbytes);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         ofs_q <= '0;
      end else if (sel_wr) begin
         sel_q <= {bus_wdata[7:0], bus_wdata[15:8]};
         ofs_q <= '0;
      end else if (data_acc) begin
         ofs_q <= ofs_sum[OFS_W] ? '1 : ofs_sum[OFS_W-1:0];
      end
   end

   // item lookup
   src_e               src;
   logic [MEM_AW-1:0]  item_base;
   logic [FIELD_W-1:0] item_len;
   logic               item_wen;

   cfgblob_keymap #(
      .NUM_ITEMS    (NUM_ITEMS),
      .MEM_AW       (MEM_AW),
      .ITEM_KEYS    (ITEM_KEYS),
      .ITEM_BASES   (ITEM_BASES),
      .ITEM_LENS    (ITEM_LENS),
      .ITEM_WRITABLE(ITEM_WRITABLE),
      .SIG_KEY      (16'h0000),
      .REV_KEY      (16'h0001)
   ) u_keymap (
      .key (sel_q),
      .src (src),
      .base(item_base),
      .len (item_len),
      .wen (item_wen)
   );

   // per-lane stream engine and byte store
   logic [DATA_BYTES-1:0][MEM_AW-1:0] mem_addr;
   logic [DATA_BYTES-1:0]             mem_we;
   logic [DATA_BYTES-1:0][7:0]        mem_wdata;
   logic [DATA_BYTES-1:0][7:0]        mem_rdata;
   logic [DATA_W-1:0]                 rd_lanes;

   cfgblob_lanes #(
      .OFS_W    (OFS_W),
      .MEM_AW   (MEM_AW),
      .SIGNATURE(SIGNATURE),
      .REVISION (REVISION)
   ) u_lanes (
      .src      (src),
      .base     (item_base),
      .len      (item_len),
      .wen      (item_wen),
      .ofs      (ofs_q),
      .nbytes   (nbytes),
      .do_wr    (data_wr),
      .wdata    (bus_wdata),
      .mem_rdata(mem_rdata),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .rd_lanes (rd_lanes)
   );

   cfgblob_store #(
      .DEPTH    (MEM_BYTES),
      .AW       (MEM_AW),
      .LANES    (DATA_BYTES),
      .INIT_BASE(INIT_BASE),
      .INIT_STEP(INIT_STEP)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_addr (mem_addr),
      .lane_we   (mem_we),
      .lane_wdata(mem_wdata),
      .lane_rdata(mem_rdata)
   );

   // response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ready <= any_acc;
         bus_rdata <= data_rd ? rd_lanes : '0;
      end
   end

endmodule

// File: rtl/cfgblob_port_chk.sv
module cfgblob_port_chk #(
   parameter int ADDR_W = 4,
   parameter int OFS_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [1:0]        bus_size,
   input logic [15:0]       sel_wdata,
   input logic [63:0]       bus_rdata,
   input logic              bus_ready,
   input logic [15:0]       sel,
   input logic [OFS_W-1:0]  ofs
);

   logic             c_acc, c_selw, c_data, c_side;
   logic [OFS_W-1:0] c_step;

   assign c_acc  = bus_rd || bus_wr;
   assign c_selw = bus_wr && !bus_rd && (bus_addr == ADDR_W'(8)) && (bus_size == 2'd1);
   assign c_data = c_acc && (bus_addr == '0) && (ofs < {OFS_W{1'b1}} - OFS_W'(8));
   assign c_side = c_acc && (bus_addr != '0) && (bus_addr != ADDR_W'(8));
   assign c_step = OFS_W'(1) << bus_size;

   // R11
   ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_acc |=> bus_ready);

   // R11
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_acc |=> !bus_ready);

   // R6
   rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_selw |=> (ofs == '0));

   // R2
   sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_selw |=> (sel == {$past(sel_wdata[7:0]), $past(sel_wdata[15:8])}));

   // R2
   sel_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(8)) |=> (bus_rdata == '0));

   // R10
   side_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_side |=> ($stable(ofs) && $stable(sel) && bus_rdata == '0));

   // R5
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_data |=> (ofs == $past(ofs) + $past(c_step)));

endmodule

bind cfgblob_port cfgblob_port_chk #(
   .ADDR_W(ADDR_W),
   .OFS_W (OFS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_size (bus_size),
   .sel_wdata(bus_wdata[15:0]),
   .bus_rdata(bus_rdata),
   .bus_ready(bus_ready),
   .sel      (sel_q),
   .ofs      (ofs_q)
);

// File: tb/tb_cfgblob_port.sv
module tb_cfgblob_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_size = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        bus_ready;

   always #10 clk = ~clk;

   cfgblob_port dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_size (bus_size),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_ready(bus_ready)
   );

   typedef struct {
      logic [63:0] exp;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // reference model built from the requirements
   logic [7:0] mm [32];
   int         msel = 0;
   int         mofs = 0;

   function automatic bit item_of(input int key, output int base, output int len, output bit wen);
      base = 0; len = 0; wen = 1'b0;
      if (key == 16'h0010) begin base = 0;  len = 8;  wen = 1'b1; return 1'b1; end
      if (key == 16'h0020) begin base = 8;  len = 6;  wen = 1'b0; return 1'b1; end
      if (key == 16'h0100) begin base = 16; len = 16; wen = 1'b1; return 1'b1; end
      return 1'b0;
   endfunction

   function automatic logic [7:0] mbyte(input int key, input int pos);
      int b, l; bit w;
      logic [7:0] sig [4] = '{8'h43, 8'h46, 8'h47, 8'h50};
      if (key == 0) return (pos < 4) ? sig[pos] : 8'h00;
      if (key == 1) return 8'h00;
      if (item_of(key, b, l, w) && pos < l) return mm[b + pos];
      return 8'h00;
   endfunction

   task automatic mwrite(input int key, input int pos, input logic [7:0] v);
      int b, l; bit w;
      if (item_of(key, b, l, w) && w && pos < l) mm[b + pos] = v;
   endtask

   task automatic acc(input bit r, input bit w, input logic [3:0] a, input logic [1:0] sz,
                      input logic [63:0] wd, input string tag);
      exp_t e;
      int   n;
      n     = 1 << sz;
      e.exp = '0;
      e.tag = tag;
      if (r && a == 0) begin
         for (int i = 0; i < n; i++) e.exp[8*i +: 8] = mbyte(msel, mofs + i);
         mofs += n;
      end else if (w && a == 0) begin
         for (int i = 0; i < n; i++) mwrite(msel, mofs + i, wd[8*i +: 8]);
         mofs += n;
      end else if (w && !r && a == 4'd8 && sz == 2'd1) begin
         msel = {wd[7:0], wd[15:8]};
         mofs = 0;
      end
      sb.push_back(e);
      @(negedge clk);
      bus_rd    = r;
      bus_wr    = w;
      bus_addr  = a;
      bus_size  = sz;
      bus_wdata = wd;
   endtask

   task automatic pick(input logic [15:0] key, input string tag);
      acc(1'b0, 1'b1, 4'd8, 2'd1, {48'h0, key[7:0], key[15:8]}, tag);
   endtask

   task automatic rd(input logic [1:0] sz, input string tag);
      acc(1'b1, 1'b0, 4'd0, sz, 64'h0, tag);
   endtask

   task automatic wr(input logic [1:0] sz, input logic [63:0] d, input string tag);
      acc(1'b0, 1'b1, 4'd0, sz, d, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per ready cycle
   always @(negedge clk) begin
      if (rst_n && bus_ready && !done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R11 ready without access", 64'h1, 64'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(bus_rdata === e.exp, e.tag, bus_rdata, e.exp);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", 64'h0, 64'h1);
         finish_run();
      end
   end

   initial begin
      for (int j = 0; j < 32; j++) mm[j] = 8'(5 + 17 * j);
      repeat (3) @(negedge clk);
      // R1 reset state
      check(bus_ready === 1'b0 && bus_rdata === 64'h0, "R1 reset outputs", {63'h0, bus_ready}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3: signature without any selector write
      rd(2'd2, "R1 R3 signature after reset");
      idle();
      // R3 byte-wise stream after explicit select, back to back with the selector
      pick(16'h0000, "R2 select signature");
      rd(2'd0, "R3 sig byte 0");
      rd(2'd0, "R3 sig byte 1");
      rd(2'd0, "R3 sig byte 2");
      rd(2'd0, "R3 sig byte 3");
      rd(2'd0, "R7 sig past end");
      // R4 revision
      pick(16'h0001, "R2 select revision");
      rd(2'd2, "R4 revision word");
      rd(2'd3, "R4 R7 revision past end");
      idle();
      // R12 initial store, R2 byte order
      pick(16'h0010, "R2 select item 0x0010");
      rd(2'd3, "R12 R2 item 0x0010 initial");
      acc(1'b1, 1'b0, 4'd8, 2'd1, 64'h0, "R2 selector reads zero");
      pick(16'h1000, "R2 swapped key");
      rd(2'd3, "R7 unknown key reads zero");
      // R5 mixed widths over 16-byte item
      pick(16'h0100, "R2 select item 0x0100");
      rd(2'd1, "R5 2-byte read");
      rd(2'd0, "R5 1-byte read");
      rd(2'd2, "R5 4-byte read");
      rd(2'd3, "R5 8-byte read");
      rd(2'd1, "R5 R7 read across end");
      // R6 rewind mid stream
      pick(16'h0100, "R6 reselect");
      rd(2'd2, "R6 rewound read");
      pick(16'h0100, "R6 reselect again");
      rd(2'd2, "R6 rewound read twice");
      idle();
      // R8 writes to writable item
      pick(16'h0010, "R8 select");
      wr(2'd2, 64'h0000_0000_DDCC_BBAA, "R8 4-byte write");
      wr(2'd0, 64'h0000_0000_0000_00EE, "R8 1-byte write");
      pick(16'h0010, "R8 reselect");
      rd(2'd3, "R8 readback");
      // R9 write straddling the end
      pick(16'h0010, "R9 select");
      rd(2'd2, "R9 skip four");
      wr(2'd3, 64'h1122_3344_5566_7788, "R9 straddle write");
      pick(16'h0010, "R9 reselect");
      rd(2'd3, "R8 R9 straddle readback");
      pick(16'h0020, "R9 select neighbour");
      rd(2'd3, "R9 neighbour untouched");
      // R9 read-only and unknown key writes
      pick(16'h0020, "R9 select read-only");
      wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R9 read-only write");
      pick(16'h0777, "R9 select unknown");
      wr(2'd3, 64'hA5A5_A5A5_A5A5_A5A5, "R9 unknown write");
      pick(16'h0020, "R9 reselect read-only");
      rd(2'd3, "R9 read-only unchanged");
      pick(16'h0100, "R9 reselect 0x0100");
      rd(2'd3, "R9 other item unchanged");
      idle();
      // R10 off-offset accesses
      pick(16'h0010, "R10 select");
      acc(1'b1, 1'b0, 4'd3, 2'd0, 64'h0, "R10 read at offset 3");
      acc(1'b0, 1'b1, 4'd5, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF, "R10 write at offset 5");
      acc(1'b0, 1'b1, 4'd9, 2'd1, 64'h0000_0000_0000_2000, "R10 write at offset 9");
      rd(2'd3, "R10 stream unmoved");
      // R11 write responses carry zero data
      wr(2'd0, 64'h77, "R11 write beyond end");
      idle();
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R11 every access answered", 64'(sb.size()), 64'h0);
      finish_run();
   end

endmodule